// File: doc/BRIEF.md
# Memory Access and Write-Back Stage

This block is the memory and register write-back part of a small single-cycle processor with an 8-bit data word. It receives a decoded instruction class, a greater-or-equal flag, the ALU result, the second register operand and the incremented program counter. From these inputs it decides whether to store. It holds the data RAM, and it presents both the raw word at the addressed location and a load value formatted to the width of the load. It also selects the value that goes back to the register file.

The ALU result is the memory address. The store data always comes from the second register operand. Stores are either unconditional, or conditional on the greater-or-equal flag. Loads come in three widths: the full word, a 4-bit half and a 2-bit byte. The narrow widths are taken from the low end of the word and sign-extended. The block is single-cycle: every output is combinational from the current inputs and the RAM contents, and the only state change is the RAM write on the rising clock edge. Control and data pins are plain levels with no handshake. The stage never stalls and always consumes the inputs it sees in each cycle.

Top module: `mem_wb_stage`

## Requirements
- R1: While reset is low, every RAM location is cleared. After reset, any address reads 0x00 until it is written.
- R2: `mem_we` is 1 exactly when `instr_cls` is 4 (unconditional store), or when `instr_cls` is 5 (conditional store) and `ge_flag` is 1. In every other case `mem_we` is 0.
- R3: A conditional store (class 5) with `ge_flag` at 0 leaves the addressed location unchanged.
- R4: A store writes `rs2_data` at address `alu_res` on the rising clock edge. Reads are combinational. A read in the same cycle as a write shows the old contents, and the new value appears after the edge.
- R5: When no store is active (classes 0–3, 6, 7), no RAM location changes.
- R6: For a word load (class 1), and for every class that is not a load, `load_val` equals `mem_rdata`.
- R7: For a half load (class 2), `load_val` is `mem_rdata[3:0]` sign-extended from bit 3 to 8 bits.
- R8: For a byte load (class 3), `load_val` is `mem_rdata[1:0]` sign-extended from bit 1 to 8 bits.
- R9: For load classes 1, 2 and 3, `wb_data` is `load_val`. For a jump (class 6), `wb_data` is `pc_next`. For class 0 (register, upper-immediate and other immediate operations), for stores (4 and 5) and for the unused code 7, `wb_data` is `alu_res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes on the rising edge |
| rst_n | input | 1 | Active-low reset, clears the RAM |
| instr_cls | input | 3 | Decoded class: 0 ALU, 1 word load, 2 half load, 3 byte load, 4 store, 5 conditional store, 6 jump, 7 unused |
| ge_flag | input | 1 | Greater-or-equal compare result for the conditional store |
| alu_res | input | 8 | ALU result, used as memory address and as write-back value |
| rs2_data | input | 8 | Second register operand, store data |
| pc_next | input | 8 | Incremented program counter |
| mem_rdata | output | 8 | Raw word at address `alu_res` |
| load_val | output | 8 | Width-formatted load value |
| wb_data | output | 8 | Selected register write-back value |
| mem_we | output | 1 | RAM write-enable for this cycle |

## Verification
The hardest case to reach from the ports is a conditional store that is suppressed. Its only visible effect is a location that did not change, so it can be seen only when that location already holds a known value that differs from the rejected data. The directed phase first writes a known value, then issues a conditional store with the flag low and different data, and then reads the location back. The random phase confines addresses to a small window so that stores, suppressed stores and loads keep landing on the same locations. It also forces sign bits on both sides for the narrow loads.

// File: rtl/mem_wb_pkg.sv
package mem_wb_pkg;
  typedef enum logic [2:0] {
    CLS_ALU  = 3'd0,
    CLS_LW   = 3'd1,
    CLS_LH   = 3'd2,
    CLS_LB   = 3'd3,
    CLS_SW   = 3'd4,
    CLS_SWGE = 3'd5,
    CLS_JMP  = 3'd6,
    CLS_RSV  = 3'd7
  } instr_cls_e;
endpackage

// File: rtl/mws_store_ctrl.sv
module mws_store_ctrl
  import mem_wb_pkg::*;
(
  input  instr_cls_e cls,
  input  logic       ge_flag,
  output logic       we
);
  always_comb begin
    unique case (cls)
      CLS_SW:   we = 1'b1;
      CLS_SWGE: we = ge_flag;
      default:  we = 1'b0;
    endcase
  end
endmodule

// File: rtl/mws_data_ram.sv
module mws_data_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];

  // R4: a write lands at the address presented at the edge
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cells[$past(addr)] == $past(wdata));

  // R5: without a write the addressed cell keeps its old word
  a_r5_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> cells[$past(addr)] == $past(rdata));
endmodule

// File: rtl/mws_load_format.sv
module mws_load_format
  import mem_wb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  instr_cls_e        cls,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] value
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  logic [DATA_W-1:0] as_word, as_half, as_byte;

  assign as_word = word;
  assign as_half = {{(DATA_W-HALF_W){word[HALF_W-1]}}, word[HALF_W-1:0]};
  assign as_byte = {{(DATA_W-BYTE_W){word[BYTE_W-1]}}, word[BYTE_W-1:0]};

  always_comb begin
    unique case (cls)
      CLS_LH:  value = as_half;
      CLS_LB:  value = as_byte;
      default: value = as_word;
    endcase
  end
endmodule

// File: rtl/mws_wb_select.sv
module mws_wb_select
  import mem_wb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  instr_cls_e        cls,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] pc_next,
  output logic [DATA_W-1:0] wb_data
);
  always_comb begin
    unique case (cls)
      CLS_LW, CLS_LH, CLS_LB: wb_data = load_val;
      CLS_JMP:                wb_data = pc_next;
      default:                wb_data = alu_res;
    endcase
  end
endmodule

// File: rtl/mem_wb_stage.sv
module mem_wb_stage
  import mem_wb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        instr_cls,
  input  logic              ge_flag,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] rs2_data,
  input  logic [DATA_W-1:0] pc_next,
  output logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] wb_data,
  output logic              mem_we
);
  instr_cls_e cls;
  assign cls = instr_cls_e'(instr_cls);

  mws_store_ctrl u_store (
    .cls     (cls),
    .ge_flag (ge_flag),
    .we      (mem_we)
  );

  // R2 / R3: stores only for the two store classes, conditional one gated
  a_r2_we_only_stores: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (instr_cls == 3'd4 || instr_cls == 3'd5));
  a_r3_cond_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && instr_cls == 3'd5) |-> ge_flag);

  mws_data_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (alu_res[ADDR_W-1:0]),
    .wdata (rs2_data),
    .rdata (mem_rdata)
  );

  mws_load_format #(.DATA_W(DATA_W)) u_fmt (
    .cls   (cls),
    .word  (mem_rdata),
    .value (load_val)
  );

  // R7 / R8: narrow loads carry their top bit upward
  a_r7_half_sign: assert property (@(posedge clk) disable iff (!rst_n)
    instr_cls == 3'd2 |-> load_val[DATA_W-1:DATA_W/2] == {(DATA_W/2){mem_rdata[DATA_W/2-1]}});
  a_r8_byte_sign: assert property (@(posedge clk) disable iff (!rst_n)
    instr_cls == 3'd3 |-> load_val[DATA_W-1:DATA_W/4] == {(DATA_W-DATA_W/4){mem_rdata[DATA_W/4-1]}});

  mws_wb_select #(.DATA_W(DATA_W)) u_wb (
    .cls      (cls),
    .alu_res  (alu_res),
    .load_val (load_val),
    .pc_next  (pc_next),
    .wb_data  (wb_data)
  );

  // R9: jumps write back the next PC, loads the formatted value
  a_r9_jump_pc: assert property (@(posedge clk) disable iff (!rst_n)
    instr_cls == 3'd6 |-> wb_data == pc_next);
  a_r9_load_path: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_cls == 3'd1 || instr_cls == 3'd2 || instr_cls == 3'd3) |-> wb_data == load_val);
endmodule

// File: tb/mem_wb_stage_test.sv
module mem_wb_stage_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] instr_cls = 3'd0;
  logic       ge_flag = 1'b0;
  logic [7:0] alu_res = 8'd0, rs2_data = 8'd0, pc_next = 8'd0;
  logic [7:0] mem_rdata, load_val, wb_data;
  logic       mem_we;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  mem_wb_stage uut (
    .clk(clk), .rst_n(rst_n), .instr_cls(instr_cls), .ge_flag(ge_flag),
    .alu_res(alu_res), .rs2_data(rs2_data), .pc_next(pc_next),
    .mem_rdata(mem_rdata), .load_val(load_val), .wb_data(wb_data), .mem_we(mem_we)
  );

  function automatic logic exp_we(input logic [2:0] c, input logic g);
    return (c == 3'd4) || (c == 3'd5 && g);
  endfunction

  function automatic logic [7:0] exp_load(input logic [2:0] c, input logic [7:0] w);
    if (c == 3'd2) return {{4{w[3]}}, w[3:0]};
    if (c == 3'd3) return {{6{w[1]}}, w[1:0]};
    return w;
  endfunction

  function automatic logic [7:0] exp_wb(input logic [2:0] c, input logic [7:0] ld,
                                        input logic [7:0] a, input logic [7:0] p);
    if (c == 3'd1 || c == 3'd2 || c == 3'd3) return ld;
    if (c == 3'd6) return p;
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Drive one cycle, check every combinational output, update the model
  task automatic step(input logic [2:0] c, input logic g, input logic [7:0] a,
                      input logic [7:0] d, input logic [7:0] p);
    logic [7:0] w, ld;
    @(negedge clk);
    instr_cls = c; ge_flag = g; alu_res = a; rs2_data = d; pc_next = p;
    #2;
    w  = model[a];
    ld = exp_load(c, w);
    check(mem_we == exp_we(c, g), "R2 write enable", mem_we, exp_we(c, g));
    check(mem_rdata == w, "R4/R5 read word", mem_rdata, w);
    if (c == 3'd2)      check(load_val == ld, "R7 half load", load_val, ld);
    else if (c == 3'd3) check(load_val == ld, "R8 byte load", load_val, ld);
    else                check(load_val == ld, "R6 word load", load_val, ld);
    check(wb_data == exp_wb(c, ld, a, p), "R9 write-back", wb_data, exp_wb(c, ld, a, p));
    if (exp_we(c, g)) model[a] = d;
  endtask

  task automatic read_at(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    instr_cls = 3'd1; ge_flag = 1'b0; alu_res = a;
    #2;
    check(mem_rdata == exp, req, mem_rdata, exp);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    read_at(8'h00, 8'h00, "R1 reset clear");
    read_at(8'h7F, 8'h00, "R1 reset clear");
    read_at(8'hFF, 8'h00, "R1 reset clear");

    // R4: same-cycle read shows old word, new word after the edge
    @(negedge clk);
    instr_cls = 3'd4; alu_res = 8'h10; rs2_data = 8'hA5; #2;
    check(mem_rdata == 8'h00, "R4 old word during write", mem_rdata, 8'h00);
    check(mem_we == 1'b1, "R2 store enables", mem_we, 1);
    model[8'h10] = 8'hA5;
    read_at(8'h10, 8'hA5, "R4 new word after edge");

    // R3: suppressed conditional store keeps the prior word
    step(3'd5, 1'b0, 8'h10, 8'h3C, 8'h00);
    read_at(8'h10, 8'hA5, "R3 suppressed store");
    step(3'd5, 1'b1, 8'h10, 8'h3C, 8'h00);
    read_at(8'h10, 8'h3C, "R3 taken conditional store");

    // R5: non-store classes with data present change nothing
    step(3'd7, 1'b1, 8'h10, 8'hFF, 8'h00);
    step(3'd6, 1'b1, 8'h10, 8'hFF, 8'h44);
    read_at(8'h10, 8'h3C, "R5 no store");

    // R7/R8: sign corners
    step(3'd4, 1'b0, 8'h20, 8'h08, 8'h00);
    step(3'd2, 1'b0, 8'h20, 8'h00, 8'h00);
    check(load_val == 8'hF8, "R7 half negative", load_val, 8'hF8);
    step(3'd4, 1'b0, 8'h21, 8'h07, 8'h00);
    step(3'd2, 1'b0, 8'h21, 8'h00, 8'h00);
    check(load_val == 8'h07, "R7 half positive", load_val, 8'h07);
    step(3'd4, 1'b0, 8'h22, 8'h5E, 8'h00);
    step(3'd3, 1'b0, 8'h22, 8'h00, 8'h00);
    check(load_val == 8'hFE, "R8 byte negative", load_val, 8'hFE);
    step(3'd4, 1'b0, 8'h23, 8'hFD, 8'h00);
    step(3'd3, 1'b0, 8'h23, 8'h00, 8'h00);
    check(load_val == 8'h01, "R8 byte positive", load_val, 8'h01);

    // R9: jump writes back PC
    step(3'd6, 1'b0, 8'h22, 8'h00, 8'h9C);
    check(wb_data == 8'h9C, "R9 jump pc", wb_data, 8'h9C);

    // Random mix on a narrow address window
    for (int n = 0; n < 600; n++) begin
      step(3'($urandom_range(7)), 1'($urandom_range(1)),
           8'h30 + 8'($urandom_range(7)), 8'($urandom), 8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule